// File: doc/BRIEF.md
# One-Wire Bus Slave Responder

This block is the device-side physical layer of a one-wire bus. The device has no clock from the master, so the block times everything from the falling edges the master puts on the shared open-drain line. It measures each low excursion. A low that lasts long enough is a bus reset: the block reports it and then answers with a presence pulse of its own. A shorter low opens a time slot. In a receive slot the block samples the line and delivers one bit. In a transmit slot it pulls the line low to send a 0, or leaves it released to send a 1.

The line arrives through `line_i`, which is synchronised inside the block. The block pulls the bus low by asserting `line_drive_o` into an external open-drain pad. The logic above this block sets `mode_read_i` and `tx_bit_i` before each slot. It consumes `rx_valid_o`/`rx_bit_o`, `tx_req_o` and `reset_o`. All durations are set in microseconds and scaled by the clock rate parameter.

Top module: `owire_slave_phy`

## Requirements
- R1: While and after `rst_n` is low, `line_drive_o`, `rx_valid_o`, `tx_req_o` and `reset_o` are 0, and they stay 0 until the bus is used.
- R2: A continuous low on the line of RST_US (480 us) produces exactly one single-cycle `reset_o` pulse for that low. A low of 470 us produces no `reset_o` and no presence drive.
- R3: After the line goes high at the end of a reset, `line_drive_o` stays 0 for PRES_WAIT_US (30 us). It is then 1 for PRES_LOW_US (120 us), and then returns to 0.
- R4: In a slot whose falling edge finds `mode_read_i`=0, `rx_valid_o` pulses for one cycle SAMPLE_US (30 us) after the edge. `rx_bit_o` then equals the line level: 1 for high, 0 for low. There is exactly one pulse per slot.
- R5: In a slot whose falling edge finds `mode_read_i`=1 and `tx_bit_i`=0, `line_drive_o` rises within a few cycles of the edge. It holds until HOLD_US (45 us) after the edge, then falls. With `tx_bit_i`=1, `line_drive_o` stays 0 for the whole slot.
- R6: `tx_req_o` is a single-cycle pulse in the cycle a read slot's falling edge is accepted, which is the cycle `tx_bit_i` is captured. It does not occur in receive slots and is never high together with `rx_valid_o`.
- R7: Changes of `mode_read_i` or `tx_bit_i` after a slot's falling edge do not change that slot's drive or produce a receive strobe.
- R8: If a slot's low continues to the reset length, reset handling wins. The slot is abandoned with the line released and no receive strobe, `reset_o` pulses, a presence pulse follows, and the next slot is handled normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw level of the shared bus line |
| mode_read_i | input | 1 | 1: next slot transmits a bit; 0: next slot receives |
| tx_bit_i | input | 1 | Bit to send in the next transmit slot |
| line_drive_o | output | 1 | 1 pulls the bus low through the open-drain pad |
| tx_req_o | output | 1 | Strobe: transmit bit taken, present the next one |
| rx_valid_o | output | 1 | Strobe: a received bit is on `rx_bit_o` |
| rx_bit_o | output | 1 | Last received bit |
| reset_o | output | 1 | Strobe: bus reset recognised |

## Verification
Two decisions can fall in the same cycle: the low-time counter reaching the reset length, and the slot sequencer, which still holds an open slot while the line stays low. Both claim the state register. The bench provokes this by opening a transmit-0 slot and having the master hold the line low past the reset length. It then judges that exactly one reset strobe appears with the line released, that no receive strobe occurs, that the presence pulse follows on time, and that a later receive slot decodes correctly. The capture of the transmit bit and the issue of its request share a cycle too. That is judged by changing `tx_bit_i` and `mode_read_i` just after the edge and checking the drive level.

// File: rtl/owire_pkg.sv
`timescale 1ns/1ps
package owire_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_RST_LOW,
    ST_PRES_WAIT,
    ST_PRES_DRIVE
  } owire_state_e;

  function automatic int unsigned cnt_width(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/owire_line_sync.sv
`timescale 1ns/1ps
module owire_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_first
      assign d = line_i;
    end else begin : g_next
      assign d = sync_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[i] <= 1'b1;
      else        sync_q[i] <= d;
    end
  end

  assign line_s_o = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= line_s_o;
  end

  assign fall_o = prev_q & ~line_s_o;

endmodule

// File: rtl/owire_low_timer.sv
`timescale 1ns/1ps
module owire_low_timer #(
  parameter int unsigned RST_CYC = 24000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s_i,
  output logic hit_o
);
  import owire_pkg::*;

  localparam int unsigned W = cnt_width(RST_CYC);
  localparam logic [W-1:0] LIM     = W'(RST_CYC);
  localparam logic [W-1:0] LIM_M1  = W'(RST_CYC - 1);

  logic [W-1:0] low_cnt_q, low_cnt_n;
  logic         cnt_en;

  always_comb begin
    low_cnt_n = low_cnt_q;
    if (line_s_i)              low_cnt_n = '0;
    else if (low_cnt_q != LIM) low_cnt_n = low_cnt_q + 1'b1;
  end

  assign cnt_en = (low_cnt_n != low_cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_cnt_q <= '0;
    else if (cnt_en) low_cnt_q <= low_cnt_n;
  end

  assign hit_o = ~line_s_i & (low_cnt_q == LIM_M1);

endmodule

// File: rtl/owire_slot_fsm.sv
`timescale 1ns/1ps
module owire_slot_fsm #(
  parameter int unsigned PRES_WAIT_CYC = 1500,
  parameter int unsigned PRES_LOW_CYC  = 6000,
  parameter int unsigned SAMPLE_CYC    = 1500,
  parameter int unsigned HOLD_CYC      = 2250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s_i,
  input  logic fall_i,
  input  logic rst_hit_i,
  input  logic mode_read_i,
  input  logic tx_bit_i,
  output logic drive_o,
  output logic tx_req_o,
  output logic rx_valid_o,
  output logic rx_bit_o
);
  import owire_pkg::*;

  localparam int unsigned END_CYC = max2(SAMPLE_CYC, HOLD_CYC);
  localparam int unsigned MAX_CYC = max2(max2(END_CYC, PRES_WAIT_CYC), PRES_LOW_CYC);
  localparam int unsigned CW      = cnt_width(MAX_CYC);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_CYC);
  localparam logic [CW-1:0] SAMP_C  = CW'(SAMPLE_CYC);
  localparam logic [CW-1:0] HOLD_C  = CW'(HOLD_CYC);
  localparam logic [CW-1:0] END_C   = CW'(END_CYC);
  localparam logic [CW-1:0] PW_LAST = CW'(PRES_WAIT_CYC - 1);
  localparam logic [CW-1:0] PL_LAST = CW'(PRES_LOW_CYC - 1);

  owire_state_e  state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          rd_q, rd_n;
  logic          bit_q, bit_n;
  logic          cap_en;
  logic          drive_q, drive_n;
  logic          rx_valid_q, rx_valid_n;
  logic          rx_bit_q, rx_bit_n;

  always_comb begin
    state_n    = state_q;
    cnt_n      = (cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
    rd_n       = rd_q;
    bit_n      = bit_q;
    cap_en     = 1'b0;
    tx_req_o   = 1'b0;
    rx_valid_n = 1'b0;
    rx_bit_n   = rx_bit_q;
    if (rst_hit_i) begin
      state_n = ST_RST_LOW;
      cnt_n   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (fall_i) begin
            state_n  = ST_SLOT;
            cnt_n    = '0;
            cap_en   = 1'b1;
            rd_n     = mode_read_i;
            bit_n    = tx_bit_i;
            tx_req_o = mode_read_i;
          end
        end
        ST_SLOT: begin
          if (!rd_q && cnt_q == SAMP_C) begin
            rx_valid_n = 1'b1;
            rx_bit_n   = line_s_i;
          end
          if (cnt_q >= END_C && line_s_i) state_n = ST_IDLE;
        end
        ST_RST_LOW: begin
          if (line_s_i) begin
            state_n = ST_PRES_WAIT;
            cnt_n   = '0;
          end
        end
        ST_PRES_WAIT: begin
          if (cnt_q == PW_LAST) begin
            state_n = ST_PRES_DRIVE;
            cnt_n   = '0;
          end
        end
        ST_PRES_DRIVE: begin
          if (cnt_q == PL_LAST) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
    drive_n = (state_n == ST_PRES_DRIVE) ||
              (state_n == ST_SLOT && rd_n && !bit_n && cnt_n < HOLD_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      drive_q    <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_bit_q   <= 1'b0;
    end else begin
      state_q    <= state_n;
      cnt_q      <= cnt_n;
      drive_q    <= drive_n;
      rx_valid_q <= rx_valid_n;
      rx_bit_q   <= rx_bit_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      bit_q <= 1'b1;
    end else if (cap_en) begin
      rd_q  <= rd_n;
      bit_q <= bit_n;
    end
  end

  assign drive_o    = drive_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_bit_o   = rx_bit_q;

endmodule

// File: rtl/owire_slave_phy.sv
`timescale 1ns/1ps
module owire_slave_phy #(
  parameter int unsigned CLK_PER_US   = 50,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RST_US       = 480,
  parameter int unsigned PRES_WAIT_US = 30,
  parameter int unsigned PRES_LOW_US  = 120,
  parameter int unsigned SAMPLE_US    = 30,
  parameter int unsigned HOLD_US      = 45
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic mode_read_i,
  input  logic tx_bit_i,
  output logic line_drive_o,
  output logic tx_req_o,
  output logic rx_valid_o,
  output logic rx_bit_o,
  output logic reset_o
);

  localparam int unsigned RST_CYC       = RST_US * CLK_PER_US;
  localparam int unsigned PRES_WAIT_CYC = PRES_WAIT_US * CLK_PER_US;
  localparam int unsigned PRES_LOW_CYC  = PRES_LOW_US * CLK_PER_US;
  localparam int unsigned SAMPLE_CYC    = SAMPLE_US * CLK_PER_US;
  localparam int unsigned HOLD_CYC      = HOLD_US * CLK_PER_US;

  logic line_s;
  logic fall;
  logic rst_hit;
  logic reset_q;

  owire_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (line_i),
    .line_s_o (line_s),
    .fall_o   (fall)
  );

  owire_low_timer #(.RST_CYC(RST_CYC)) u_low (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_s_i (line_s),
    .hit_o    (rst_hit)
  );

  owire_slot_fsm #(
    .PRES_WAIT_CYC (PRES_WAIT_CYC),
    .PRES_LOW_CYC  (PRES_LOW_CYC),
    .SAMPLE_CYC    (SAMPLE_CYC),
    .HOLD_CYC      (HOLD_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_s_i    (line_s),
    .fall_i      (fall),
    .rst_hit_i   (rst_hit),
    .mode_read_i (mode_read_i),
    .tx_bit_i    (tx_bit_i),
    .drive_o     (line_drive_o),
    .tx_req_o    (tx_req_o),
    .rx_valid_o  (rx_valid_o),
    .rx_bit_o    (rx_bit_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reset_q <= 1'b0;
    else        reset_q <= rst_hit;
  end

  assign reset_o = reset_q;

endmodule

// File: rtl/owire_slave_phy_chk.sv
`timescale 1ns/1ps
module owire_slave_phy_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_bit_i,
  input logic line_drive_o,
  input logic tx_req_o,
  input logic rx_valid_o,
  input logic reset_o
);

  assert_reset_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reset_o |=> !reset_o);

  assert_reset_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_o |-> !line_drive_o);

  assert_rx_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  assert_tx0_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_o && !tx_bit_i) |=> line_drive_o);

  assert_tx1_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_o && tx_bit_i) |=> !line_drive_o);

  assert_txreq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |=> !tx_req_o);

  assert_txreq_not_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |-> !rx_valid_o);

endmodule

bind owire_slave_phy owire_slave_phy_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_bit_i     (tx_bit_i),
  .line_drive_o (line_drive_o),
  .tx_req_o     (tx_req_o),
  .rx_valid_o   (rx_valid_o),
  .reset_o      (reset_o)
);

// File: tb/owire_slave_phy_bench.sv
`timescale 1ns/1ps
module owire_slave_phy_bench;

  localparam int unsigned US = 1000;
  localparam int unsigned WATCHDOG_CYC = 180000;

  logic clk;
  logic rst_n;
  logic master_low;
  logic mode_read;
  logic tx_bit;
  logic bus;
  logic line_drive;
  logic tx_req;
  logic rx_valid;
  logic rx_bit;
  logic reset_stb;

  int checks;
  int errors;
  int rx_cnt;
  int txreq_cnt;
  int rst_cnt;
  logic rx_last;
  bit done;

  assign bus = ~(master_low | line_drive);

  owire_slave_phy u_owire_slave_phy (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (bus),
    .mode_read_i  (mode_read),
    .tx_bit_i     (tx_bit),
    .line_drive_o (line_drive),
    .tx_req_o     (tx_req),
    .rx_valid_o   (rx_valid),
    .rx_bit_o     (rx_bit),
    .reset_o      (reset_stb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt  <= rx_cnt + 1;
      rx_last <= rx_bit;
    end
    if (tx_req)    txreq_cnt <= txreq_cnt + 1;
    if (reset_stb) rst_cnt   <= rst_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // {read, tx_bit, expected, low_us[6:0]}
  localparam int NV = 8;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 7'd5},
    {1'b0, 1'b1, 1'b0, 7'd65},
    {1'b0, 1'b1, 1'b1, 7'd2},
    {1'b0, 1'b1, 1'b0, 7'd62},
    {1'b1, 1'b0, 1'b1, 7'd1},
    {1'b1, 1'b1, 1'b0, 7'd1},
    {1'b1, 1'b0, 1'b1, 7'd2},
    {1'b1, 1'b1, 1'b0, 7'd2}
  };

  task automatic run_slot(input logic rd, input logic tb, input logic exp, input int low_us);
    int rx0, tq0;
    rx0 = rx_cnt; tq0 = txreq_cnt;
    mode_read = rd; tx_bit = tb;
    master_low = 1'b1;
    #(low_us * US);
    master_low = 1'b0;
    if (rd) begin
      #((15 - low_us) * US);
      chk(line_drive == exp, "R5 drive at 15us", line_drive, exp);
      #(35 * US);
      chk(line_drive == 1'b0, "R5 released at 50us", line_drive, 0);
      #(20 * US);
    end else begin
      #((70 - low_us) * US);
    end
    #(5 * US);
    if (rd) begin
      chk(txreq_cnt - tq0 == 1, "R6 one request per read slot", txreq_cnt - tq0, 1);
      chk(rx_cnt == rx0, "R6 no rx strobe in read slot", rx_cnt - rx0, 0);
    end else begin
      chk(rx_cnt - rx0 == 1, "R4 one strobe per write slot", rx_cnt - rx0, 1);
      chk(rx_last == exp, "R4 received bit", rx_last, exp);
      chk(txreq_cnt == tq0, "R6 no request in write slot", txreq_cnt - tq0, 0);
    end
  endtask

  task automatic check_presence(input string tag);
    #(25 * US);
    chk(line_drive == 1'b0, {tag, " R3 quiet before presence"}, line_drive, 0);
    #(10 * US);
    chk(line_drive == 1'b1, {tag, " R3 presence low"}, line_drive, 1);
    #(110 * US);
    chk(line_drive == 1'b1, {tag, " R3 presence still low"}, line_drive, 1);
    #(10 * US);
    chk(line_drive == 1'b0, {tag, " R3 presence released"}, line_drive, 0);
    #(5 * US);
  endtask

  initial begin
    #(WATCHDOG_CYC * 20);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int r0, x0;
    checks = 0; errors = 0; done = 1'b0;
    rx_cnt = 0; txreq_cnt = 0; rst_cnt = 0; rx_last = 1'b0;
    rst_n = 1'b0; master_low = 1'b0; mode_read = 1'b0; tx_bit = 1'b1;
    #95;
    rst_n = 1'b1;
    #(2 * US);
    // R1: idle state after reset
    chk(line_drive == 1'b0, "R1 drive idle", line_drive, 0);
    chk(rx_cnt == 0 && !rx_valid, "R1 no rx strobe", rx_cnt, 0);
    chk(txreq_cnt == 0 && !tx_req, "R1 no request", txreq_cnt, 0);
    chk(rst_cnt == 0 && !reset_stb, "R1 no reset strobe", rst_cnt, 0);

    for (int i = 0; i < NV; i++) begin
      run_slot(VEC[i][9], VEC[i][8], VEC[i][7], int'(VEC[i][6:0]));
    end

    // R2/R3: plain reset then presence
    r0 = rst_cnt;
    master_low = 1'b1;
    #(485 * US);
    master_low = 1'b0;
    chk(rst_cnt - r0 == 1, "R2 one reset strobe", rst_cnt - r0, 1);
    check_presence("plain");

    // R2 boundary: 470 us low is not a reset
    r0 = rst_cnt;
    mode_read = 1'b0;
    master_low = 1'b1;
    #(470 * US);
    master_low = 1'b0;
    #(40 * US);
    chk(rst_cnt == r0, "R2 470us gives no reset", rst_cnt - r0, 0);
    chk(line_drive == 1'b0, "R2 470us gives no presence", line_drive, 0);
    #(20 * US);

    // R8: transmit-0 slot held low into reset length
    r0 = rst_cnt; x0 = rx_cnt;
    mode_read = 1'b1; tx_bit = 1'b0;
    master_low = 1'b1;
    #(485 * US);
    master_low = 1'b0;
    chk(rst_cnt - r0 == 1, "R8 reset wins over open slot", rst_cnt - r0, 1);
    chk(rx_cnt == x0, "R8 no rx strobe in abandoned slot", rx_cnt - x0, 0);
    check_presence("R8");
    run_slot(1'b0, 1'b1, 1'b1, 4);

    // R7: late changes of mode and bit are ignored
    x0 = rx_cnt;
    mode_read = 1'b1; tx_bit = 1'b0;
    master_low = 1'b1;
    #(1 * US);
    master_low = 1'b0;
    #(2 * US);
    tx_bit = 1'b1; mode_read = 1'b0;
    #(12 * US);
    chk(line_drive == 1'b1, "R7 drive kept after late change", line_drive, 1);
    #(60 * US);
    chk(rx_cnt == x0, "R7 no rx strobe after late mode change", rx_cnt - x0, 0);
    chk(line_drive == 1'b0, "R7 released at slot end", line_drive, 0);

    finish_run();
  end

endmodule